// File: doc/BRIEF.md
# Halted-Memory Load and Dump Sequencer

This block lets a host fill a memory inside a halted design under test and read it back afterwards, without the design running during either access. It owns the functional clock-run enable, the clock-source select of the target memories and the design reset. It walks a fixed bring-up order: halt the clocks, move the memory clock to the instrumentation source once the clocks are quiet, fill the chosen memory with address/value pairs, then put the design in reset, start its clocks and let go of reset. After the test the host halts the clocks again and pulls address/value pairs back out.

The host drives a 3-bit command code with a memory index, an address and a data word over a valid/ready port. Dumped words come back on a second valid/ready port. On the memory side the block drives a one-hot memory select, address, write data, write and read strobes, and a byte-lane enable vector. For a dual-port memory the one port that can both read and write is the one wired here. Every lane of the byte-lane vector is driven active on every instrumented access, so a memory with per-byte write strobes is always written and read whole.

Top module: `memload_seq`

## Requirements
- R1: While reset is held and right after it, the clock-run output is 1, the clock-select and design-reset outputs are 0, no memory is selected or strobed, the host port is ready and no dump word is valid.
- R2: Command code 1 (halt) is acted on only in the idle phase. On the clock edge that accepts it, clock-run goes to 0. Clock-select stays 0 for that one cycle. A memory strobe is only ever high while clock-run is 0 and clock-select is 1.
- R3: Clock-select changes only while clock-run is 0, and was 0 the cycle before as well. After a halt, clock-select rises one cycle after clock-run falls. It then stays high SETTLE cycles with the host port not ready before the load phase opens.
- R4: In the load and dump phases, code 2 (select) picks memory index cmd_mem. An index of NMEM or more leaves the choice unchanged. In the load phase, code 3 (write) drives one cycle of write strobe with cmd_addr, cmd_data and the one-hot bit of the chosen memory.
- R5: Code 4 (go) in the load phase raises design reset and drops clock-select on the same edge, with clocks still stopped, for SETTLE cycles. Clock-run then rises with reset still high, for RST_HOLD cycles. Reset then falls, and one cycle later the run phase opens.
- R6: Code 5 (stop) in the run phase drops clock-run for one cycle. Clock-select then rises for SETTLE cycles, after which the dump phase opens.
- R7: The byte-lane vector is all ones in every cycle with a write or read strobe, and all zeros otherwise.
- R8: Code 6 (read) in the dump phase drives one cycle of read strobe. The memory returns data in the following cycle. The word and its address appear on the dump port two cycles after acceptance and stay unchanged until rsp_ready is seen high. The host port is not ready from acceptance until the word is taken.
- R9: Code 7 (done) in the dump phase drops clock-select with clocks stopped for SETTLE cycles. The block then returns to idle with clock-run at 1.
- R10: A command code that the current phase does not list, including code 0, is accepted and changes no output.
- R11: The host port is not ready in any timed phase (halting, switching, reset and clock start, restoring).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instrumentation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Command accepted on this edge when valid |
| cmd_op | input | 3 | Command code (1 halt, 2 select, 3 write, 4 go, 5 stop, 6 read, 7 done) |
| cmd_mem | input | MSEL_W | Memory index for select |
| cmd_addr | input | AW | Word address for write and read |
| cmd_data | input | DW | Value for write |
| rsp_valid | output | 1 | Dumped word present |
| rsp_ready | input | 1 | Host takes the dumped word |
| rsp_addr | output | AW | Address of the dumped word |
| rsp_data | output | DW | Dumped word |
| clk_run | output | 1 | Functional clocks enabled |
| clk_sel | output | 1 | Memory clock source: 0 functional, 1 instrumentation |
| dut_rst | output | 1 | Active-high reset to the design under test |
| mem_cs | output | NMEM | One-hot memory select during an access |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_be | output | LANES | Byte-lane enables |
| mem_rdata | input | DW | Read data, valid the cycle after mem_re |

## Verification
The bench builds the block with three memories, so the 2-bit index has one code, 3, that names no memory, and the ignored-select path can be hit. A 4-bit address lets writes and reads reach both the lowest and the highest word. A 16-bit word gives two byte lanes whose full activation can be seen. SETTLE of 3 and RST_HOLD of 2 keep each timed window short enough that two full load-run-dump rounds, with dump back-pressure and out-of-phase commands, are compared cycle by cycle.

// File: rtl/memload_pkg.sv
package memload_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_HALT,
        PH_SWITCH,
        PH_LOAD,
        PH_RST_ON,
        PH_CLK_ON,
        PH_RST_OFF,
        PH_RUN,
        PH_HALT2,
        PH_SWITCH2,
        PH_DUMP,
        PH_RESTORE
    } phase_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_HALT   = 3'd1,
        OP_SELECT = 3'd2,
        OP_WRITE  = 3'd3,
        OP_GO     = 3'd4,
        OP_STOP   = 3'd5,
        OP_READ   = 3'd6,
        OP_DONE   = 3'd7
    } op_e;

    // {clock run, clock select, design reset} held in each phase
    function automatic logic [2:0] phase_drive(phase_e p);
        logic [2:0] v;
        unique case (p)
            PH_IDLE:    v = 3'b100;
            PH_HALT:    v = 3'b000;
            PH_SWITCH:  v = 3'b010;
            PH_LOAD:    v = 3'b010;
            PH_RST_ON:  v = 3'b001;
            PH_CLK_ON:  v = 3'b101;
            PH_RST_OFF: v = 3'b100;
            PH_RUN:     v = 3'b100;
            PH_HALT2:   v = 3'b000;
            PH_SWITCH2: v = 3'b010;
            PH_DUMP:    v = 3'b010;
            PH_RESTORE: v = 3'b000;
            default:    v = 3'b100;
        endcase
        return v;
    endfunction

    // phases that wait on the host rather than on a timer
    function automatic logic phase_open(phase_e p);
        return (p == PH_IDLE) || (p == PH_LOAD) || (p == PH_RUN) || (p == PH_DUMP);
    endfunction

endpackage

// File: rtl/memload_timer.sv
module memload_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

    // a freshly loaded count only ever moves down by one per cycle
    assert_timer_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) && $past(cnt_q) != '0 |-> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/memload_port.sv
module memload_port #(
    parameter int NMEM   = 4,
    parameter int AW     = 10,
    parameter int DW     = 32,
    parameter int MSEL_W = 2,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic [MSEL_W-1:0] sel_idx,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              rsp_ready,
    output logic [NMEM-1:0]   mem_cs,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [LANES-1:0]  mem_be,
    output logic              rsp_valid,
    output logic [AW-1:0]     rsp_addr,
    output logic [DW-1:0]     rsp_data,
    output logic              busy
);

    typedef struct packed {
        logic [NMEM-1:0]  cs;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic             we;
        logic             re;
        logic [LANES-1:0] be;
        logic             stage;
        logic             rsp_valid;
        logic [AW-1:0]    rsp_addr;
        logic [DW-1:0]    rsp_data;
    } port_t;

    port_t st_d, st_q;
    logic [NMEM-1:0] cs_dec;

    for (genvar g = 0; g < NMEM; g++) begin : g_dec
        assign cs_dec[g] = (sel_idx == MSEL_W'(g));
    end

    always_comb begin
        st_d       = st_q;
        st_d.we    = 1'b0;
        st_d.re    = 1'b0;
        st_d.cs    = '0;
        st_d.be    = '0;
        st_d.stage = st_q.re;
        if (st_q.rsp_valid && rsp_ready) begin
            st_d.rsp_valid = 1'b0;
        end
        if (st_q.stage) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_addr  = st_q.addr;
            st_d.rsp_data  = mem_rdata;
        end
        if (wr_go || rd_go) begin
            st_d.cs   = cs_dec;
            st_d.addr = addr;
            st_d.be   = '1;
            st_d.we   = wr_go;
            st_d.re   = rd_go;
            if (wr_go) begin
                st_d.wdata = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_cs    = st_q.cs;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.wdata;
    assign mem_we    = st_q.we;
    assign mem_re    = st_q.re;
    assign mem_be    = st_q.be;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_addr  = st_q.rsp_addr;
    assign rsp_data  = st_q.rsp_data;
    assign busy      = st_q.re | st_q.stage | st_q.rsp_valid;

    assert_lanes_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (&mem_be));

    assert_lanes_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we || mem_re) |-> (mem_be == '0) && (mem_cs == '0));

    assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> $countones(mem_cs) == 1);

    assert_word_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_addr));

    assert_word_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(mem_re, 2));

endmodule

// File: rtl/memload_seq.sv
module memload_seq
    import memload_pkg::*;
#(
    parameter int NMEM     = 4,
    parameter int AW       = 10,
    parameter int DW       = 32,
    parameter int SETTLE   = 4,
    parameter int RST_HOLD = 8,
    localparam int MSEL_W  = (NMEM > 1) ? $clog2(NMEM) : 1,
    localparam int LANES   = (DW + 7) / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [MSEL_W-1:0] cmd_mem,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [DW-1:0]     cmd_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [AW-1:0]     rsp_addr,
    output logic [DW-1:0]     rsp_data,
    output logic              clk_run,
    output logic              clk_sel,
    output logic              dut_rst,
    output logic [NMEM-1:0]   mem_cs,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [LANES-1:0]  mem_be,
    input  logic [DW-1:0]     mem_rdata
);

    localparam int TMAX = (SETTLE > RST_HOLD) ? SETTLE : RST_HOLD;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0]     T_ONE    = '0;
    localparam logic [CW-1:0]     T_SETTLE = CW'(SETTLE - 1);
    localparam logic [CW-1:0]     T_HOLD   = CW'(RST_HOLD - 1);
    localparam logic [MSEL_W:0]   NMEM_V   = (MSEL_W + 1)'(NMEM);

    typedef struct packed {
        phase_e            ph;
        logic [MSEL_W-1:0] msel;
        logic              run;
        logic              sel;
        logic              rst;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          wr_go, rd_go;
    logic          accept;
    logic          busy;
    logic          sel_ok;
    op_e           op;

    assign cmd_ready = phase_open(fsm_q.ph) && !busy;
    assign accept    = cmd_valid && cmd_ready;
    assign op        = op_e'(cmd_op);
    assign sel_ok    = ({1'b0, cmd_mem} < NMEM_V);

    always_comb begin
        fsm_d    = fsm_q;
        tmr_load = 1'b0;
        tmr_val  = T_ONE;
        wr_go    = 1'b0;
        rd_go    = 1'b0;
        unique case (fsm_q.ph)
            PH_IDLE: begin
                if (accept && op == OP_HALT) begin
                    fsm_d.ph = PH_HALT;
                    tmr_load = 1'b1;
                    tmr_val  = T_ONE;
                end
            end
            PH_HALT: begin
                if (tmr_done) begin
                    fsm_d.ph = PH_SWITCH;
                    tmr_load = 1'b1;
                    tmr_val  = T_SETTLE;
                end
            end
            PH_SWITCH: begin
                if (tmr_done) fsm_d.ph = PH_LOAD;
            end
            PH_LOAD: begin
                if (accept) begin
                    case (op)
                        OP_SELECT: if (sel_ok) fsm_d.msel = cmd_mem;
                        OP_WRITE:  wr_go = 1'b1;
                        OP_GO: begin
                            fsm_d.ph = PH_RST_ON;
                            tmr_load = 1'b1;
                            tmr_val  = T_SETTLE;
                        end
                        default: ;
                    endcase
                end
            end
            PH_RST_ON: begin
                if (tmr_done) begin
                    fsm_d.ph = PH_CLK_ON;
                    tmr_load = 1'b1;
                    tmr_val  = T_HOLD;
                end
            end
            PH_CLK_ON: begin
                if (tmr_done) begin
                    fsm_d.ph = PH_RST_OFF;
                    tmr_load = 1'b1;
                    tmr_val  = T_ONE;
                end
            end
            PH_RST_OFF: begin
                if (tmr_done) fsm_d.ph = PH_RUN;
            end
            PH_RUN: begin
                if (accept && op == OP_STOP) begin
                    fsm_d.ph = PH_HALT2;
                    tmr_load = 1'b1;
                    tmr_val  = T_ONE;
                end
            end
            PH_HALT2: begin
                if (tmr_done) begin
                    fsm_d.ph = PH_SWITCH2;
                    tmr_load = 1'b1;
                    tmr_val  = T_SETTLE;
                end
            end
            PH_SWITCH2: begin
                if (tmr_done) fsm_d.ph = PH_DUMP;
            end
            PH_DUMP: begin
                if (accept) begin
                    case (op)
                        OP_SELECT: if (sel_ok) fsm_d.msel = cmd_mem;
                        OP_READ:   rd_go = 1'b1;
                        OP_DONE: begin
                            fsm_d.ph = PH_RESTORE;
                            tmr_load = 1'b1;
                            tmr_val  = T_SETTLE;
                        end
                        default: ;
                    endcase
                end
            end
            PH_RESTORE: begin
                if (tmr_done) fsm_d.ph = PH_IDLE;
            end
            default: fsm_d.ph = PH_IDLE;
        endcase
        {fsm_d.run, fsm_d.sel, fsm_d.rst} = phase_drive(fsm_d.ph);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q      <= '0;
            fsm_q.ph   <= PH_IDLE;
            fsm_q.run  <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    memload_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    memload_port #(
        .NMEM   (NMEM),
        .AW     (AW),
        .DW     (DW),
        .MSEL_W (MSEL_W),
        .LANES  (LANES)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .sel_idx   (fsm_q.msel),
        .addr      (cmd_addr),
        .wdata     (cmd_data),
        .mem_rdata (mem_rdata),
        .rsp_ready (rsp_ready),
        .mem_cs    (mem_cs),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_be    (mem_be),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr),
        .rsp_data  (rsp_data),
        .busy      (busy)
    );

    assign clk_run = fsm_q.run;
    assign clk_sel = fsm_q.sel;
    assign dut_rst = fsm_q.rst;

    assert_access_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> !clk_run && clk_sel);

    assert_select_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_sel) |-> !clk_run && !$past(clk_run));

    assert_write_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> fsm_q.ph == PH_LOAD);

    assert_reset_before_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dut_rst) |-> !clk_run);

    assert_release_while_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dut_rst) |-> clk_run && $past(clk_run));

    assert_read_in_dump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> fsm_q.ph == PH_DUMP && !cmd_ready);

    assert_timed_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_open(fsm_q.ph) |-> !cmd_ready);

endmodule

// File: tb/memload_seq_bench.sv
module memload_seq_bench;

    localparam int NMEM     = 3;
    localparam int AW       = 4;
    localparam int DW       = 16;
    localparam int SETTLE   = 3;
    localparam int RST_HOLD = 2;
    localparam int MSW      = 2;
    localparam int LANES    = 2;
    localparam int DEPTH    = 1 << AW;

    localparam int M_IDLE = 0, M_HALT = 1, M_SWITCH = 2, M_LOAD = 3, M_RSTON = 4,
                   M_CLKON = 5, M_RSTOFF = 6, M_RUN = 7, M_HALT2 = 8, M_SWITCH2 = 9,
                   M_DUMP = 10, M_RESTORE = 11;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic           cmd_ready;
    logic [2:0]     cmd_op = '0;
    logic [MSW-1:0] cmd_mem = '0;
    logic [AW-1:0]  cmd_addr = '0;
    logic [DW-1:0]  cmd_data = '0;
    logic           rsp_valid;
    logic           rsp_ready = 1'b1;
    logic [AW-1:0]  rsp_addr;
    logic [DW-1:0]  rsp_data;
    logic           clk_run, clk_sel, dut_rst;
    logic [NMEM-1:0] mem_cs;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic           mem_we, mem_re;
    logic [LANES-1:0] mem_be;
    logic [DW-1:0]  mem_rdata = '0;

    int vectors = 0;
    int misses  = 0;

    always #2 clk = ~clk;

    memload_seq #(
        .NMEM (NMEM), .AW (AW), .DW (DW), .SETTLE (SETTLE), .RST_HOLD (RST_HOLD)
    ) u_memload_seq (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_op (cmd_op),
        .cmd_mem (cmd_mem), .cmd_addr (cmd_addr), .cmd_data (cmd_data),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_addr (rsp_addr), .rsp_data (rsp_data),
        .clk_run (clk_run), .clk_sel (clk_sel), .dut_rst (dut_rst),
        .mem_cs (mem_cs), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_we (mem_we), .mem_re (mem_re), .mem_be (mem_be), .mem_rdata (mem_rdata)
    );

    // behavioural memories written only through the block
    logic [DW-1:0] bmem [NMEM][DEPTH];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < NMEM; m++)
                for (int a = 0; a < DEPTH; a++) bmem[m][a] <= '0;
        end else begin
            for (int m = 0; m < NMEM; m++) begin
                if (mem_cs[m] && mem_we) bmem[m][mem_addr] <= mem_wdata;
                if (mem_cs[m] && mem_re) mem_rdata <= bmem[m][mem_addr];
            end
        end
    end

    // reference model, host-intent view
    logic [DW-1:0] shadow [NMEM][DEPTH];
    int  m_ph = M_IDLE, m_tmr = 0, m_sel = 0, m_rd_wait = 0, m_rd_mem = 0;
    bit  m_we = 0, m_re = 0, m_rsp_v = 0, started = 0;
    logic [AW-1:0] m_addr = '0, m_rd_addr = '0, m_rsp_addr = '0;
    logic [DW-1:0] m_wdata = '0, m_rsp_data = '0;

    function automatic bit m_open(int p);
        return p == M_IDLE || p == M_LOAD || p == M_RUN || p == M_DUMP;
    endfunction
    function automatic int m_run(int p);
        return (p == M_IDLE || p == M_CLKON || p == M_RSTOFF || p == M_RUN) ? 1 : 0;
    endfunction
    function automatic int m_clksel(int p);
        return (p == M_SWITCH || p == M_LOAD || p == M_SWITCH2 || p == M_DUMP) ? 1 : 0;
    endfunction
    function automatic int m_rst(int p);
        return (p == M_RSTON || p == M_CLKON) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        bit acc;
        started = 1;
        if (!rst_n) begin
            m_ph = M_IDLE; m_tmr = 0; m_sel = 0; m_rd_wait = 0;
            m_we = 0; m_re = 0; m_rsp_v = 0;
            for (int m = 0; m < NMEM; m++)
                for (int a = 0; a < DEPTH; a++) shadow[m][a] = '0;
        end else begin
            acc = cmd_valid && m_open(m_ph) && m_rd_wait == 0 && !m_rsp_v;
            m_we = 0;
            m_re = 0;
            if (m_rsp_v && rsp_ready) m_rsp_v = 0;
            if (m_rd_wait > 0) begin
                m_rd_wait--;
                if (m_rd_wait == 0) begin
                    m_rsp_v    = 1;
                    m_rsp_addr = m_rd_addr;
                    m_rsp_data = shadow[m_rd_mem][m_rd_addr];
                end
            end
            case (m_ph)
                M_IDLE: if (acc && cmd_op == 3'd1) begin m_ph = M_HALT; m_tmr = 1; end
                M_LOAD: if (acc) begin
                    case (cmd_op)
                        3'd2: if (int'(cmd_mem) < NMEM) m_sel = int'(cmd_mem);
                        3'd3: begin
                            m_we = 1; m_addr = cmd_addr; m_wdata = cmd_data;
                            shadow[m_sel][cmd_addr] = cmd_data;
                        end
                        3'd4: begin m_ph = M_RSTON; m_tmr = SETTLE; end
                        default: ;
                    endcase
                end
                M_RUN: if (acc && cmd_op == 3'd5) begin m_ph = M_HALT2; m_tmr = 1; end
                M_DUMP: if (acc) begin
                    case (cmd_op)
                        3'd2: if (int'(cmd_mem) < NMEM) m_sel = int'(cmd_mem);
                        3'd6: begin
                            m_re = 1; m_addr = cmd_addr; m_rd_addr = cmd_addr;
                            m_rd_mem = m_sel; m_rd_wait = 2;
                        end
                        3'd7: begin m_ph = M_RESTORE; m_tmr = SETTLE; end
                        default: ;
                    endcase
                end
                default: begin
                    m_tmr--;
                    if (m_tmr == 0) begin
                        case (m_ph)
                            M_HALT:    begin m_ph = M_SWITCH;  m_tmr = SETTLE;   end
                            M_SWITCH:  m_ph = M_LOAD;
                            M_RSTON:   begin m_ph = M_CLKON;   m_tmr = RST_HOLD; end
                            M_CLKON:   begin m_ph = M_RSTOFF;  m_tmr = 1;        end
                            M_RSTOFF:  m_ph = M_RUN;
                            M_HALT2:   begin m_ph = M_SWITCH2; m_tmr = SETTLE;   end
                            M_SWITCH2: m_ph = M_DUMP;
                            default:   m_ph = M_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, what, $time, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            cmp("R2", "clk_run", int'(clk_run), m_run(m_ph));
            cmp("R3", "clk_sel", int'(clk_sel), m_clksel(m_ph));
            cmp("R5", "dut_rst", int'(dut_rst), m_rst(m_ph));
            cmp("R11", "cmd_ready", int'(cmd_ready),
                (m_open(m_ph) && m_rd_wait == 0 && !m_rsp_v) ? 1 : 0);
            cmp("R4", "mem_we", int'(mem_we), int'(m_we));
            cmp("R8", "mem_re", int'(mem_re), int'(m_re));
            cmp("R4", "mem_cs", int'(mem_cs), (m_we || m_re) ? (1 << m_sel) : 0);
            cmp("R7", "mem_be", int'(mem_be), (m_we || m_re) ? ((1 << LANES) - 1) : 0);
            if (m_we || m_re) cmp("R4", "mem_addr", int'(mem_addr), int'(m_addr));
            if (m_we) cmp("R4", "mem_wdata", int'(mem_wdata), int'(m_wdata));
            cmp("R8", "rsp_valid", int'(rsp_valid), int'(m_rsp_v));
            if (m_rsp_v) begin
                cmp("R8", "rsp_data", int'(rsp_data), int'(m_rsp_data));
                cmp("R8", "rsp_addr", int'(rsp_addr), int'(m_rsp_addr));
            end
        end
    end

    task automatic send(input int op, input int mem, input int addr, input int data);
        cmd_valid = 1'b1;
        cmd_op    = op[2:0];
        cmd_mem   = mem[MSW-1:0];
        cmd_addr  = addr[AW-1:0];
        cmd_data  = data[DW-1:0];
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    task automatic wait_open();
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic read_word(input int addr, input int stall);
        if (stall > 0) rsp_ready = 1'b0;
        send(6, 0, addr, 0);
        repeat (stall + 1) @(negedge clk);
        rsp_ready = 1'b1;
        wait_open();
    endtask

    function automatic int pattern(int seed, int m, int a);
        return (seed * 37 + m * 911 + a * 133 + 5) & 16'hffff;
    endfunction

    task automatic round(input int seed);
        // R10: codes outside the idle phase's list change nothing
        send(3, 0, 1, 16'h1234);
        send(4, 0, 0, 0);
        send(6, 0, 0, 0);
        send(7, 0, 0, 0);
        send(0, 0, 0, 0);
        cmp("R10", "idle clk_run", int'(clk_run), 1);
        cmp("R10", "idle mem_we", int'(mem_we), 0);
        send(1, 0, 0, 0);                       // halt
        wait_open();
        cmp("R3", "load clk_sel", int'(clk_sel), 1);
        send(2, 1, 0, 0);
        for (int a = 0; a < 4; a++) send(3, 0, a + seed, pattern(seed, 1, a + seed));
        send(2, 3, 0, 0);                       // R4: index 3 names no memory
        send(3, 0, 9, pattern(seed, 1, 9));
        send(2, 0, 0, 0);
        send(3, 0, 0, pattern(seed, 0, 0));
        send(3, 0, DEPTH - 1, pattern(seed, 0, DEPTH - 1));
        send(2, 2, 0, 0);
        send(3, 0, 5, pattern(seed, 2, 5));
        send(3, 0, 5, pattern(seed, 2, 6));     // overwrite
        send(1, 0, 0, 0);                       // R10: ignored in load
        send(5, 0, 0, 0);
        send(6, 0, 0, 0);
        send(7, 0, 0, 0);
        cmp("R10", "load clk_sel", int'(clk_sel), 1);
        send(4, 0, 0, 0);                       // go
        wait_open();
        cmp("R5", "run dut_rst", int'(dut_rst), 0);
        cmp("R5", "run clk_run", int'(clk_run), 1);
        send(6, 0, 0, 0);                       // R10: ignored in run
        send(3, 0, 0, 0);
        repeat (3) @(negedge clk);
        send(5, 0, 0, 0);                       // stop
        wait_open();
        cmp("R6", "dump clk_sel", int'(clk_sel), 1);
        cmp("R6", "dump clk_run", int'(clk_run), 0);
        send(3, 0, 5, 16'hdead);                // R10: write ignored in dump
        send(4, 0, 0, 0);
        read_word(5, 3);                        // still memory 2
        send(2, 1, 0, 0);
        for (int a = 0; a < 4; a++) read_word(a + seed, (a == 2) ? 4 : 0);
        read_word(9, 0);
        send(2, 0, 0, 0);
        read_word(0, 0);
        read_word(DEPTH - 1, 1);
        read_word(7, 0);                        // never written this round
        send(7, 0, 0, 0);                       // done
        wait_open();
        cmp("R9", "idle clk_run", int'(clk_run), 1);
        cmp("R9", "idle clk_sel", int'(clk_sel), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp("R1", "reset clk_run", int'(clk_run), 1);
        cmp("R1", "reset clk_sel", int'(clk_sel), 0);
        cmp("R1", "reset dut_rst", int'(dut_rst), 0);
        cmp("R1", "reset cmd_ready", int'(cmd_ready), 1);
        cmp("R1", "reset rsp_valid", int'(rsp_valid), 0);
        cmp("R1", "reset mem_cs", int'(mem_cs), 0);
        rst_n = 1'b1;
        @(negedge clk);
        round(1);
        repeat (2) @(negedge clk);
        round(6);
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        misses++;
        $display("FAIL R11 watchdog expired: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule